// File: doc/BRIEF.md
# Bus Power Sampler with Pull-Up and Drive Gating

This block watches a bus-power-valid input and turns its level into two enables: one for the D+ pull-up that announces the device to the host, and one that lets a parallel drive interface put its pins on the wire. The input is not followed continuously. It is read once on the first clock after reset and then once every sample period, 20 ms by default. The period is counted in clock cycles that are derived from the clock frequency parameter. Between two samples both enables hold their value, whatever the input does.

A configuration byte chooses what happens to the drive interface when power is absent. With the keep-drive bit clear, the interface floats whenever the last sample saw no power. With the bit set, the interface stays driven. The same byte is read only at the sample instants. Separately, a low-power indicator pin is driven low while the device is active and released to high impedance while it is suspended. This pin follows the suspend flag one clock later and does not wait for a sample.

Top module: `bus_power_gate`

## Requirements
- R1: While reset is asserted, `pullupEn`, `ifaceOe`, `lowPwrOe` and `lowPwrOut` are all 0, so the pull-up is released and both the interface and the indicator float.
- R2: The first sample is taken at the first rising clock edge after reset is released, and the outputs reflect the input at that edge.
- R3: Later samples are taken every `CLK_HZ/1000*PERIOD_MS` clock edges after the first. That is 1,000,000 edges at the defaults, which is 20 ms at 50 MHz.
- R4: After each sample, `pullupEn` equals the sampled power-valid value: 1 enables the pull-up and 0 releases it.
- R5: When bit 4 of `cfgByte` is 0 at a sample, `ifaceOe` takes the sampled power-valid value, so the interface floats while power is absent.
- R6: When bit 4 of `cfgByte` is 1 at a sample, `ifaceOe` becomes 1 whatever the sampled value. The other bits of `cfgByte` have no effect.
- R7: Between samples, `pullupEn` and `ifaceOe` keep their value even if `pwrValidIn` or `cfgByte` changes.
- R8: One clock after `suspendIn` is 0, `lowPwrOe` is 1, and one clock after it is 1, `lowPwrOe` is 0. `lowPwrOut` is always 0, so the pin is driven low while active and tristated during suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of frequency `CLK_HZ` |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrValidIn | input | 1 | Bus-power-valid level, already synchronous to `clk` |
| cfgByte | input | 8 | Configuration byte; bit 4 set keeps the interface driven without power |
| suspendIn | input | 1 | 1 while the device is suspended |
| pullupEn | output | 1 | Enable for the D+ pull-up |
| ifaceOe | output | 1 | Output enable for the parallel drive interface pins |
| lowPwrOut | output | 1 | Drive value of the low-power indicator pin |
| lowPwrOe | output | 1 | Output enable of the low-power indicator pin |

## Verification
The bench changes the power input and the keep-drive bit just after each sample. It then checks at the last cycle before the next sample that the enables have not moved. A design that sampled continuously, or that counted a period one cycle short, would show the new value there. It steps through all four power and keep-drive combinations and also sets every configuration bit except bit 4. A design that decoded the wrong bit would leave the interface driven with power absent. The first sample is checked on the very first edge after reset, which catches a counter that starts at zero and delays the first sample by a full period. The suspend flag is toggled in the middle of a period to show that the indicator follows it at once, while the enables stay put.

// File: rtl/bus_power_gate_pkg.sv
package bus_power_gate_pkg;

  // Strobes passed from the sample timer to the datapath.
  typedef struct packed {
    logic sampleTick;  // one-cycle pulse: capture the power input now
  } ctrlStrobes_t;

  // Cycles in one sample period for a given clock and period in ms.
  function automatic int periodCycles(input int clkHz, input int periodMs);
    return (clkHz / 1000) * periodMs;
  endfunction

endpackage

// File: rtl/bus_power_sample_timer.sv
module bus_power_sample_timer
  import bus_power_gate_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int PERIOD_MS = 20
) (
  input  logic         clk,
  input  logic         rstN,
  output ctrlStrobes_t strobes
);

  localparam int PERIOD_CYC = periodCycles(CLK_HZ, PERIOD_MS);
  localparam int CNT_W      = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

  logic [CNT_W-1:0] cycleCnt;
  logic             tickNow;

  // The counter starts at its last value, so the first edge after reset is a sample.
  assign tickNow = (cycleCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleCnt <= LAST;
    end else if (tickNow) begin
      cycleCnt <= '0;
    end else begin
      cycleCnt <= cycleCnt + 1'b1;
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.sampleTick = tickNow;
  end

  generate
    if (PERIOD_CYC > 1) begin : gSpacing
      // R3: two samples are never on adjacent cycles when the period is longer than one cycle
      a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
        strobes.sampleTick |=> !strobes.sampleTick);
    end
  endgenerate

endmodule

// File: rtl/bus_power_gate_dp.sv
module bus_power_gate_dp
  import bus_power_gate_pkg::*;
#(
  parameter int CFG_W    = 8,
  parameter int KEEP_BIT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic             pwrValidIn,
  input  logic [CFG_W-1:0] cfgByte,
  input  logic             suspendIn,
  output logic             pullupEn,
  output logic             ifaceOe,
  output logic             lowPwrOut,
  output logic             lowPwrOe
);

  logic pullupQ;
  logic ifaceOeQ;
  logic lowPwrOeQ;
  logic keepDrive;
  logic unusedCfg;

  assign keepDrive = cfgByte[KEEP_BIT];
  assign unusedCfg = ^cfgByte;

  // Enables move only when the timer says to sample.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pullupQ  <= 1'b0;
      ifaceOeQ <= 1'b0;
    end else if (strobes.sampleTick) begin
      pullupQ  <= pwrValidIn;
      ifaceOeQ <= pwrValidIn | keepDrive;
    end
  end

  // The indicator follows the suspend flag and ignores the sample timer.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowPwrOeQ <= 1'b0;
    end else begin
      lowPwrOeQ <= !suspendIn;
    end
  end

  assign pullupEn  = pullupQ;
  assign ifaceOe   = ifaceOeQ;
  assign lowPwrOut = 1'b0;
  assign lowPwrOe  = lowPwrOeQ;

  // R4: after a sample the pull-up follows the sampled input
  a_r4_pullup_follows: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sampleTick |=> (pullupEn == $past(pwrValidIn)));

  // R5: keep-drive clear, so the interface enable matches the pull-up enable
  a_r5_float_without_power: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.sampleTick && !keepDrive) |=> (ifaceOe == pullupEn));

  // R6: keep-drive set, so the interface stays driven
  a_r6_keep_driven: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.sampleTick && keepDrive) |=> ifaceOe);

  // R7: no sample, no change
  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.sampleTick |=> ($stable(pullupEn) && $stable(ifaceOe)));

  // R8: the indicator output enable is the inverse of last cycle's suspend flag
  a_r8_lowpwr_track: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (lowPwrOe == !$past(suspendIn)));

  // R8: the indicator drive value is always low
  a_r8_lowpwr_level: assert property (@(posedge clk) disable iff (!rstN)
    lowPwrOut == 1'b0);

endmodule

// File: rtl/bus_power_gate.sv
module bus_power_gate
  import bus_power_gate_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int PERIOD_MS = 20,
  parameter int KEEP_BIT  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrValidIn,
  input  logic [7:0] cfgByte,
  input  logic       suspendIn,
  output logic       pullupEn,
  output logic       ifaceOe,
  output logic       lowPwrOut,
  output logic       lowPwrOe
);

  ctrlStrobes_t strobes;

  bus_power_sample_timer #(
    .CLK_HZ   (CLK_HZ),
    .PERIOD_MS(PERIOD_MS)
  ) timer_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes)
  );

  bus_power_gate_dp #(
    .CFG_W   (8),
    .KEEP_BIT(KEEP_BIT)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .pwrValidIn(pwrValidIn),
    .cfgByte   (cfgByte),
    .suspendIn (suspendIn),
    .pullupEn  (pullupEn),
    .ifaceOe   (ifaceOe),
    .lowPwrOut (lowPwrOut),
    .lowPwrOe  (lowPwrOe)
  );

endmodule

// File: tb/bus_power_gate_tb_top.sv
module bus_power_gate_tb_top;

  localparam int CLK_HZ    = 50_000;   // scaled so one 20 ms period is 1000 cycles
  localparam int PERIOD_MS = 20;
  localparam int P         = (CLK_HZ / 1000) * PERIOD_MS;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwrValidIn = 1'b0;
  logic [7:0] cfgByte = 8'h00;
  logic       suspendIn = 1'b0;
  logic       pullupEn, ifaceOe, lowPwrOut, lowPwrOe;

  int checkCnt = 0;
  int failCnt  = 0;
  int edgeNo   = 0;

  typedef struct {
    string req;
    logic  pu;
    logic  oe;
  } expItem_t;

  expItem_t expQ[$];

  always #10 clk = ~clk;   // 50 MHz

  bus_power_gate #(
    .CLK_HZ   (CLK_HZ),
    .PERIOD_MS(PERIOD_MS),
    .KEEP_BIT (4)
  ) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .pwrValidIn(pwrValidIn),
    .cfgByte   (cfgByte),
    .suspendIn (suspendIn),
    .pullupEn  (pullupEn),
    .ifaceOe   (ifaceOe),
    .lowPwrOut (lowPwrOut),
    .lowPwrOe  (lowPwrOe)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Count rising edges since reset release; edges 1, 1+P, 1+2P ... are sample edges (R2, R3).
  always @(posedge clk) begin
    if (!rstN) edgeNo = 0;
    else edgeNo = edgeNo + 1;
  end

  // Monitor: after each sample edge, pop the expected item and compare.
  always @(negedge clk) begin
    if (rstN && edgeNo >= 1 && ((edgeNo - 1) % P) == 0) begin
      if (expQ.size() == 0) begin
        checkCnt++;
        failCnt++;
        $display("FAIL R3 unexpected sample edge %0d actual=none expected=queued", edgeNo);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(it.req, "pullupEn", pullupEn, it.pu);
        check(it.req, "ifaceOe", ifaceOe, it.oe);
      end
    end
  end

  // Driver: called on the negedge just before a sample edge.
  task automatic driveSample(input string req, input logic pin, input logic [7:0] cfg);
    expItem_t it;
    pwrValidIn = pin;
    cfgByte    = cfg;
    it.req = req;
    it.pu  = pin;
    it.oe  = pin | cfg[4];
    expQ.push_back(it);
  endtask

  logic expPu, expOe;

  // Runs from the pre-sample negedge to the next pre-sample negedge.
  task automatic runPeriod(input string req, input logic pin, input logic [7:0] cfg);
    driveSample(req, pin, cfg);
    expPu = pin;
    expOe = pin | cfg[4];
    @(negedge clk);               // offset 1: monitor compares here
    pwrValidIn = ~pin;            // R7: inputs change right after the sample
    cfgByte    = cfg ^ 8'h10;
    @(negedge clk);               // offset 2
    check("R7", "pullupEn hold early", pullupEn, expPu);
    check("R7", "ifaceOe hold early", ifaceOe, expOe);
    suspendIn = 1'b1;
    @(negedge clk);               // offset 3
    check("R8", "lowPwrOe in suspend", lowPwrOe, 1'b0);
    check("R8", "lowPwrOut level", lowPwrOut, 1'b0);
    check("R7", "pullupEn unaffected by suspend", pullupEn, expPu);
    suspendIn = 1'b0;
    @(negedge clk);               // offset 4
    check("R8", "lowPwrOe active", lowPwrOe, 1'b1);
    repeat (P - 4) @(negedge clk);  // offset P: just before the next sample edge
    check("R3", "pullupEn hold at period end", pullupEn, expPu);
    check("R3", "ifaceOe hold at period end", ifaceOe, expOe);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "pullupEn in reset", pullupEn, 1'b0);
    check("R1", "ifaceOe in reset", ifaceOe, 1'b0);
    check("R1", "lowPwrOe in reset", lowPwrOe, 1'b0);
    check("R1", "lowPwrOut in reset", lowPwrOut, 1'b0);
    rstN = 1'b1;                  // the next rising edge is the first sample
    runPeriod("R2", 1'b1, 8'h00);  // first sample, power present
    runPeriod("R5", 1'b0, 8'h00);  // no power, floats
    runPeriod("R6", 1'b0, 8'h10);  // no power, kept driven
    runPeriod("R6", 1'b1, 8'h10);  // power, kept driven
    runPeriod("R4", 1'b0, 8'h00);  // pull-up released again
    runPeriod("R6", 1'b0, 8'hEF);  // all bits except bit 4: still floats
    runPeriod("R4", 1'b1, 8'hEF);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    #(200_000 * 20);
    checkCnt++;
    failCnt++;
    $display("FAIL R3 watchdog actual=timeout expected=finished");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule